// File: doc/BRIEF.md
# Precise Trap Sequencer

This block sequences exceptions for an in-order pipeline with five stages. When the execute stage flags a fault, the block does not redirect fetch at once. In that same cycle it kills the instruction in execute and every younger slot in decode and fetch, and it holds the program counter. It then lets the older instructions in the memory and write-back stages finish their writes. The trap is taken only once that work has drained.

On the trap it captures the PC and cause of the faulting instruction, redirects fetch to a fixed handler address and enters a masked, in-exception mode. While that mode is set, no later fault can disturb the saved PC. A return request reloads the saved PC into fetch, so the faulting instruction runs again. The first fault that arrives while masked is parked and taken after the return.

The datapath is outside the block. The stages ahead of execute appear only as valid bits, and the controlled state appears as PC and redirect outputs.

Top module: `trap_sequencer`

## Requirements
- R1: After reset, squash_o, redirect_o and in_exc_o are 0, and epc_o, cause_o and drain_len_o are 0.
- R2: A fault is accepted when ex_valid_i and ex_fault_i are both 1, in_exc_o is 0 and no drain is in progress. In the cycle of acceptance squash_o is 1 and redirect_o stays 0.
- R3: The drain length N is the number of bits set in older_valid_i (bit 1 = memory stage, bit 0 = write-back stage), sampled in the acceptance cycle. squash_o stays 1 for the N cycles after that cycle. redirect_o is 0 throughout, and epc_o keeps its old value.
- R4: redirect_o rises in cycle t+1+N, where t is the acceptance cycle. With N = 0 this is the very next cycle, and drain_len_o then reads N.
- R5: In that same cycle, epc_o holds the PC of the faulting instruction, cause_o holds its cause, redirect_pc_o equals HANDLER_VEC, in_exc_o is 1 and squash_o is 0.
- R6: While in_exc_o is 1, a fault neither squashes nor redirects, and epc_o and cause_o do not change.
- R7: When eret_i is 1 and in_exc_o is 1, the next cycle shows redirect_o = 1, redirect_pc_o = epc_o and in_exc_o = 0. When eret_i is 1 and in_exc_o is 0, no redirect follows.
- R8: The first fault seen while masked is held. Later masked faults are dropped. In the cycle after the return, the held fault is accepted as in R2 to R5 with its own PC and cause, and it takes priority over a new fault in execute in that cycle.
- R9: A fault flag with ex_valid_i at 0, or a fault arriving while a drain is in progress, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid_i | input | 1 | Execute stage holds a live instruction |
| ex_fault_i | input | 1 | Execute stage instruction raised a fault |
| ex_cause_i | input | CAUSE_W | Fault cause code |
| ex_pc_i | input | PC_W | PC of the execute stage instruction |
| older_valid_i | input | OLDER_STG | Valid bits of the older stages (bit 1 memory, bit 0 write-back) |
| eret_i | input | 1 | Return-from-exception request |
| squash_o | output | 1 | Clear fetch/decode/execute write enables and hold the PC |
| redirect_o | output | 1 | One-cycle fetch redirect |
| redirect_pc_o | output | PC_W | Redirect target |
| epc_o | output | PC_W | Saved faulting PC |
| cause_o | output | CAUSE_W | Saved fault cause |
| in_exc_o | output | 1 | In-exception mode, which masks further faults |
| drain_len_o | output | CNT_W | Drain cycles of the last trap |

## Verification
Suppose the drain counter is loaded or decremented wrongly. The redirect pulse then lands one or more cycles away from t+1+N, or squash_o drops early, and either shows up within three cycles of the fault. A bad pending latch or mask bit shows up later. Either epc_o changes during masked operation, or the wrong PC appears in epc_o on the trap that follows a return. The bench therefore checks every drain cycle individually, and it checks the saved PC and cause on each trap.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DRAIN = 1'b1
  } drain_st_e;

endpackage

// File: rtl/trap_fault_sel.sv
module trap_fault_sel #(
  parameter int PC_W    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ex_valid_i,
  input  logic               ex_fault_i,
  input  logic [CAUSE_W-1:0] ex_cause_i,
  input  logic [PC_W-1:0]    ex_pc_i,
  input  logic               masked_i,
  input  logic               idle_i,
  output logic               accept_o,
  output logic [PC_W-1:0]    acc_pc_o,
  output logic [CAUSE_W-1:0] acc_cause_o
);

  logic               pend_v;
  logic [PC_W-1:0]    pend_pc;
  logic [CAUSE_W-1:0] pend_cause;
  logic               new_flt;

  always_comb begin
    new_flt     = ex_valid_i & ex_fault_i;
    // a parked fault is older than anything now in execute
    accept_o    = idle_i & ~masked_i & (pend_v | new_flt);
    acc_pc_o    = pend_v ? pend_pc    : ex_pc_i;
    acc_cause_o = pend_v ? pend_cause : ex_cause_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v     <= 1'b0;
      pend_pc    <= '0;
      pend_cause <= '0;
    end else if (masked_i && new_flt && !pend_v) begin
      pend_v     <= 1'b1;
      pend_pc    <= ex_pc_i;
      pend_cause <= ex_cause_i;
    end else if (accept_o && pend_v) begin
      pend_v     <= 1'b0;
    end
  end

endmodule

// File: rtl/trap_drain_seq.sv
module trap_drain_seq
  import trap_seq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept_i,
  input  logic [CNT_W-1:0] older_cnt_i,
  output logic             idle_o,
  output logic             draining_o,
  output logic             trap_go_o,
  output logic             trap_imm_o,
  output logic [CNT_W-1:0] trap_n_o
);

  drain_st_e        st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] n_q;

  always_comb begin
    idle_o     = (st == ST_IDLE);
    draining_o = (st == ST_DRAIN);
    trap_imm_o = accept_i && (older_cnt_i == '0);
    trap_go_o  = trap_imm_o || (draining_o && cnt == CNT_W'(1));
    trap_n_o   = trap_imm_o ? '0 : n_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      cnt <= '0;
      n_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (accept_i && older_cnt_i != '0) begin
            st  <= ST_DRAIN;
            cnt <= older_cnt_i;
            n_q <= older_cnt_i;
          end
        end
        ST_DRAIN: begin
          if (cnt == CNT_W'(1)) st <= ST_IDLE;
          cnt <= cnt - CNT_W'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs #(
  parameter int                PC_W        = 32,
  parameter int                CAUSE_W     = 5,
  parameter int                CNT_W       = 2,
  parameter logic [PC_W-1:0]   HANDLER_VEC = 'h100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trap_go_i,
  input  logic [PC_W-1:0]    trap_pc_i,
  input  logic [CAUSE_W-1:0] trap_cause_i,
  input  logic [CNT_W-1:0]   trap_n_i,
  input  logic               eret_i,
  output logic [PC_W-1:0]    epc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               in_exc_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    redirect_pc_o,
  output logic [CNT_W-1:0]   drain_len_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_o         <= '0;
      cause_o       <= '0;
      in_exc_o      <= 1'b0;
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
      drain_len_o   <= '0;
    end else if (trap_go_i) begin
      epc_o         <= trap_pc_i;
      cause_o       <= trap_cause_i;
      in_exc_o      <= 1'b1;
      redirect_o    <= 1'b1;
      redirect_pc_o <= HANDLER_VEC;
      drain_len_o   <= trap_n_i;
    end else if (eret_i && in_exc_o) begin
      in_exc_o      <= 1'b0;
      redirect_o    <= 1'b1;
      redirect_pc_o <= epc_o;
    end else begin
      redirect_o    <= 1'b0;
    end
  end

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer #(
  parameter int              PC_W        = 32,
  parameter int              CAUSE_W     = 5,
  parameter int              OLDER_STG   = 2,
  parameter logic [PC_W-1:0] HANDLER_VEC = 'h100,
  localparam int             CNT_W       = $clog2(OLDER_STG + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ex_valid_i,
  input  logic                 ex_fault_i,
  input  logic [CAUSE_W-1:0]   ex_cause_i,
  input  logic [PC_W-1:0]      ex_pc_i,
  input  logic [OLDER_STG-1:0] older_valid_i,
  input  logic                 eret_i,
  output logic                 squash_o,
  output logic                 redirect_o,
  output logic [PC_W-1:0]      redirect_pc_o,
  output logic [PC_W-1:0]      epc_o,
  output logic [CAUSE_W-1:0]   cause_o,
  output logic                 in_exc_o,
  output logic [CNT_W-1:0]     drain_len_o
);

  logic [CNT_W-1:0]   older_cnt;
  logic               accept;
  logic [PC_W-1:0]    acc_pc;
  logic [CAUSE_W-1:0] acc_cause;
  logic               idle;
  logic               draining;
  logic               trap_go;
  logic               trap_imm;
  logic [CNT_W-1:0]   trap_n;
  logic [PC_W-1:0]    hold_pc;
  logic [CAUSE_W-1:0] hold_cause;
  logic [PC_W-1:0]    trap_pc;
  logic [CAUSE_W-1:0] trap_cause;

  always_comb begin
    older_cnt = '0;
    for (int i = 0; i < OLDER_STG; i++) begin
      older_cnt = older_cnt + CNT_W'(older_valid_i[i]);
    end
  end

  trap_fault_sel #(
    .PC_W    (PC_W),
    .CAUSE_W (CAUSE_W)
  ) u_sel (
    .clk         (clk),
    .rst         (rst),
    .ex_valid_i  (ex_valid_i),
    .ex_fault_i  (ex_fault_i),
    .ex_cause_i  (ex_cause_i),
    .ex_pc_i     (ex_pc_i),
    .masked_i    (in_exc_o),
    .idle_i      (idle),
    .accept_o    (accept),
    .acc_pc_o    (acc_pc),
    .acc_cause_o (acc_cause)
  );

  trap_drain_seq #(
    .CNT_W (CNT_W)
  ) u_drain (
    .clk         (clk),
    .rst         (rst),
    .accept_i    (accept),
    .older_cnt_i (older_cnt),
    .idle_o      (idle),
    .draining_o  (draining),
    .trap_go_o   (trap_go),
    .trap_imm_o  (trap_imm),
    .trap_n_o    (trap_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_pc    <= '0;
      hold_cause <= '0;
    end else if (accept) begin
      hold_pc    <= acc_pc;
      hold_cause <= acc_cause;
    end
  end

  always_comb begin
    trap_pc    = trap_imm ? acc_pc    : hold_pc;
    trap_cause = trap_imm ? acc_cause : hold_cause;
    squash_o   = accept | draining;
  end

  trap_state_regs #(
    .PC_W        (PC_W),
    .CAUSE_W     (CAUSE_W),
    .CNT_W       (CNT_W),
    .HANDLER_VEC (HANDLER_VEC)
  ) u_regs (
    .clk           (clk),
    .rst           (rst),
    .trap_go_i     (trap_go),
    .trap_pc_i     (trap_pc),
    .trap_cause_i  (trap_cause),
    .trap_n_i      (trap_n),
    .eret_i        (eret_i),
    .epc_o         (epc_o),
    .cause_o       (cause_o),
    .in_exc_o      (in_exc_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .drain_len_o   (drain_len_o)
  );

endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk #(
  parameter int              PC_W        = 32,
  parameter int              CAUSE_W     = 5,
  parameter logic [PC_W-1:0] HANDLER_VEC = 'h100
) (
  input logic               clk,
  input logic               rst,
  input logic               squash_o,
  input logic               redirect_o,
  input logic [PC_W-1:0]    redirect_pc_o,
  input logic [PC_W-1:0]    epc_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic               in_exc_o
);

  // R5
  trap_entry_vec_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(in_exc_o) |-> (redirect_o && redirect_pc_o == HANDLER_VEC));

  // R3
  trap_after_squash_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(in_exc_o) |-> $past(squash_o));

  // R6
  epc_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_exc_o) |-> ($stable(epc_o) && $stable(cause_o)));

  // R6
  mask_no_squash_chk: assert property (@(posedge clk) disable iff (rst)
    in_exc_o |-> !squash_o);

  // R7
  return_target_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(in_exc_o) |-> (redirect_o && redirect_pc_o == epc_o));

endmodule

bind trap_sequencer trap_sequencer_chk #(
  .PC_W        (PC_W),
  .CAUSE_W     (CAUSE_W),
  .HANDLER_VEC (HANDLER_VEC)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .squash_o      (squash_o),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .epc_o         (epc_o),
  .cause_o       (cause_o),
  .in_exc_o      (in_exc_o)
);

// File: tb/trap_sequencer_tb.sv
`timescale 1ns/1ps
module trap_sequencer_tb;

  localparam int          PC_W = 32;
  localparam int          CW   = 5;
  localparam logic [31:0] VEC  = 32'h0000_0100;

  logic          clk = 1'b0;
  logic          rst;
  logic          ex_valid, ex_fault, eret;
  logic [CW-1:0] ex_cause;
  logic [31:0]   ex_pc;
  logic [1:0]    older;
  logic          squash_o, redirect_o, in_exc_o;
  logic [31:0]   redirect_pc_o, epc_o;
  logic [CW-1:0] cause_o;
  logic [1:0]    drain_len_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  trap_sequencer #(
    .PC_W        (PC_W),
    .CAUSE_W     (CW),
    .OLDER_STG   (2),
    .HANDLER_VEC (VEC)
  ) u_dut (
    .clk           (clk),
    .rst           (rst),
    .ex_valid_i    (ex_valid),
    .ex_fault_i    (ex_fault),
    .ex_cause_i    (ex_cause),
    .ex_pc_i       (ex_pc),
    .older_valid_i (older),
    .eret_i        (eret),
    .squash_o      (squash_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .epc_o         (epc_o),
    .cause_o       (cause_o),
    .in_exc_o      (in_exc_o),
    .drain_len_o   (drain_len_o)
  );

  function automatic int drain_of(input logic [1:0] ov);
    return int'(ov[0]) + int'(ov[1]);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    ex_valid = 1'b0; ex_fault = 1'b0; eret = 1'b0; older = 2'b00;
  endtask

  task automatic finish_trap(input int n, input logic [31:0] pc, input logic [CW-1:0] cs,
                             input logic [31:0] prev_epc, input bit noise);
    for (int i = 0; i < n; i++) begin
      if (noise) begin
        ex_valid = 1'b1; ex_fault = 1'b1; ex_pc = ~pc; ex_cause = cs ^ 5'h1f;
      end
      #1;
      chk("R3 squash during drain", squash_o, 1);
      chk("R3 no early redirect", redirect_o, 0);
      chk("R3 epc held while draining", epc_o, prev_epc);
      step();
      idle();
    end
    #1;
    chk("R4 redirect at t+1+N", redirect_o, 1);
    chk("R4 drain length", drain_len_o, n);
    chk("R5 handler vector", redirect_pc_o, VEC);
    chk("R5 epc", epc_o, pc);
    chk("R9 cause of first fault", cause_o, cs);
    chk("R5 in_exc set", in_exc_o, 1);
    chk("R5 squash released", squash_o, 0);
    step();
    chk("R4 redirect one cycle", redirect_o, 0);
  endtask

  task automatic do_trap(input logic [31:0] pc, input logic [CW-1:0] cs,
                         input logic [1:0] ov, input bit noise);
    logic [31:0] prev;
    prev = epc_o;
    ex_valid = 1'b1; ex_fault = 1'b1; ex_pc = pc; ex_cause = cs; older = ov;
    #1;
    chk("R2 squash in detect cycle", squash_o, 1);
    chk("R2 no redirect in detect cycle", redirect_o, 0);
    step();
    idle();
    finish_trap(drain_of(ov), pc, cs, prev, noise);
  endtask

  task automatic do_eret(input logic [31:0] back_pc);
    eret = 1'b1;
    step();
    eret = 1'b0;
    #1;
    chk("R7 return redirect", redirect_o, 1);
    chk("R7 return target", redirect_pc_o, back_pc);
    chk("R7 mode cleared", in_exc_o, 0);
    step();
  endtask

  task automatic masked_return(input logic [31:0] pcx, input logic [CW-1:0] csx,
                               input logic [31:0] pcy, input logic [31:0] pcz,
                               input logic [1:0] ov);
    logic [31:0] e;
    logic [CW-1:0] ec;
    e = epc_o; ec = cause_o;
    ex_valid = 1'b1; ex_fault = 1'b1; ex_pc = pcx; ex_cause = csx;
    #1;
    chk("R6 no squash while masked", squash_o, 0);
    step();
    ex_pc = pcy; ex_cause = ~csx;
    #1;
    chk("R6 epc unchanged while masked", epc_o, e);
    chk("R6 cause unchanged while masked", cause_o, ec);
    chk("R6 no redirect while masked", redirect_o, 0);
    step();
    idle();
    eret = 1'b1;
    step();
    eret = 1'b0;
    older = ov;
    ex_valid = 1'b1; ex_fault = 1'b1; ex_pc = pcz; ex_cause = 5'h0;
    #1;
    chk("R7 return redirect", redirect_o, 1);
    chk("R7 return target", redirect_pc_o, e);
    chk("R8 pending taken after return", squash_o, 1);
    step();
    idle();
    finish_trap(drain_of(ov), pcx, csx, e, 1'b0);
    do_eret(pcx);
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed_r;
    seed_r = $urandom(32'h5EED_0042);
    idle();
    ex_pc = '0; ex_cause = '0;
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    #1;
    chk("R1 squash", squash_o, 0);
    chk("R1 redirect", redirect_o, 0);
    chk("R1 in_exc", in_exc_o, 0);
    chk("R1 epc", epc_o, 0);
    chk("R1 cause", cause_o, 0);
    chk("R1 drain_len", drain_len_o, 0);
    step();

    // R4 empty older set: trap next cycle
    do_trap(32'h0000_1000, 5'd3, 2'b00, 1'b0);
    do_eret(32'h0000_1000);
    // R3 full drain with younger faults noise (R9)
    do_trap(32'h0000_2004, 5'd7, 2'b11, 1'b1);
    do_eret(32'h0000_2004);
    // memory stage only
    do_trap(32'h0000_3008, 5'd9, 2'b10, 1'b0);
    // R8 masked fault parked, second dropped, beats new fault
    masked_return(32'h0000_4000, 5'd12, 32'h0000_5000, 32'h0000_6000, 2'b01);

    // R9 fault flag without valid
    ex_fault = 1'b1; ex_valid = 1'b0; ex_pc = 32'hDEAD_0000;
    #1;
    chk("R9 invalid fault ignored", squash_o, 0);
    step();
    idle();
    #1;
    chk("R9 no trap from invalid fault", in_exc_o, 0);
    // R7 eret with mode clear is ignored
    eret = 1'b1;
    step();
    eret = 1'b0;
    #1;
    chk("R7 stray return ignored", redirect_o, 0);
    step();

    for (int k = 0; k < 40; k++) begin
      logic [31:0]   rpc;
      logic [CW-1:0] rcs;
      logic [1:0]    rov;
      rpc = $urandom() & 32'hFFFF_FFFC;
      rcs = CW'($urandom());
      rov = 2'($urandom());
      do_trap(rpc, rcs, rov, 1'($urandom()));
      if ($urandom() % 2 == 0)
        do_eret(rpc);
      else
        masked_return($urandom() & 32'hFFFF_FFFC, CW'($urandom()),
                      $urandom(), $urandom(), 2'($urandom()));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule